// File: doc/BRIEF.md
# Pulse Period and Width Measurement Timer

This block times an external digital signal against a chosen tick rate. The signal is brought into the clock domain through a short synchroniser chain. Software selects one of three edge pairings: falling edge to falling edge, rising edge to rising edge, or width, where every transition ends one interval and starts the next. On each qualifying edge the 16-bit running count is copied into a capture register and the counter restarts from zero. A one-cycle event pulse reports the new value to the surrounding logic.

Counting only happens when a separate start input is high and the mode register selects measurement operation. The tick is one of four prescaler strobes supplied from outside. If the counter wraps between edges, a sticky overflow flag is set. Software cannot set this flag. It clears only when the mode register is rewritten while running, and only once a further tick has occurred after the flag was set.

Top module: `pulse_meter`

## Requirements
- R1: After synchronous reset, `cfg_rdata` reads 8'h00, `cap_value` is 0 and `cap_event` is low.
- R2: The mode register layout is as follows. Bits [1:0] hold the operation mode, and 2'b10 means measurement. Bits [3:2] hold the edge pairing. Bit 4 is reserved and always reads 0. Bit 5 is the overflow flag, which is read-only, so writing 1 to it has no effect. Bits [7:6] hold the tick source. Writing 8'hFF after reset reads back 8'hCF.
- R3: Edge pairing 2'b01 captures on each rising edge of `pin_in`, and falling edges do not capture. The captured value is the number of ticks counted since the previous restart edge. A tick in the same cycle as a restart is not counted.
- R4: Edge pairing 2'b00 captures on each falling edge, and rising edges do not capture.
- R5: Edge pairing 2'b10 captures on both edges. Each capture gives the tick count of the phase that has just ended.
- R6: `cap_event` rises on the third rising clock edge after `pin_in` changes and is high for exactly one cycle. `cap_value` changes only together with `cap_event` and holds otherwise.
- R7: The first qualifying edge after counting becomes enabled only restarts the counter. It raises no `cap_event`.
- R8: While `run` is low, or while the operation mode is not 2'b10, the counter stays at 0 and no capture occurs.
- R9: Edge pairing 2'b11 is reserved. With it selected, no capture occurs on any edge.
- R10: The tick source field selects the count strobe: 2'b00 selects `tick_base`, 2'b01 selects `tick_div8`, 2'b10 selects `tick_div32` and 2'b11 selects `tick_aux32`. The strobes that are not selected have no effect on the count.
- R11: When the counter wraps from FFFFh to 0000h, the overflow flag (bit 5) is set. With a tick in every cycle and no edges, it reads 1 exactly 65536 cycles after counting starts.
- R12: A mode register write clears the overflow flag only if `run` is high and at least one selected tick has occurred after the cycle in which the flag was set. Otherwise the flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| cfg_rdata | output | 8 | Mode register read data, including the overflow flag |
| run | input | 1 | Start bit; counting is enabled when high |
| tick_base | input | 1 | Base-rate count strobe |
| tick_div8 | input | 1 | Divide-by-8 count strobe |
| tick_div32 | input | 1 | Divide-by-32 count strobe |
| tick_aux32 | input | 1 | Auxiliary slow clock divided by 32, as a strobe |
| pin_in | input | 1 | Asynchronous signal being measured |
| cap_value | output | 16 | Last captured count |
| cap_event | output | 1 | One-cycle pulse when a capture occurs |

## Verification
A corrupted edge-pairing or priming state appears at the ports within three clock cycles of the next transition on `pin_in`. It shows as a missing, extra or early `cap_event`. A counter that restarts or steps wrongly appears in `cap_value` at the next capture, as a count that differs from the tick total between the edges. A wrong overflow state stays hidden until a wrap or a mode register write. Its first visible sign is bit 5 of `cfg_rdata`, read one cycle after that event.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam logic [1:0] OP_MEAS = 2'b10;

    typedef enum logic [1:0] {
        PAIR_FALL = 2'b00,
        PAIR_RISE = 2'b01,
        PAIR_BOTH = 2'b10,
        PAIR_NONE = 2'b11
    } pair_e;

    typedef struct packed {
        logic [1:0] src;
        pair_e      pair;
        logic [1:0] op;
    } mode_t;

    function automatic logic edge_hit(input pair_e pair, input logic rise, input logic fall);
        case (pair)
            PAIR_FALL: edge_hit = fall;
            PAIR_RISE: edge_hit = rise;
            PAIR_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pm_edge_det.sv
module pm_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/pm_tick_mux.sv
module pm_tick_mux #(
    parameter int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] strobes,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    assign tick = strobes[sel];
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    always_ff @(posedge clk) begin
        if (rst || !en || restart)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    assign wrap = en && !restart && tick && (cnt == {CNT_W{1'b1}});
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
    import pm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             run,
    input  logic             tick_base,
    input  logic             tick_div8,
    input  logic             tick_div32,
    input  logic             tick_aux32,
    input  logic             pin_in,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_event
);
    mode_t            mode;
    logic             ovf, ovf_armed, primed;
    logic             rise, fall, tick_sel, wrap, meas_on, hit;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '{src: 2'b00, pair: PAIR_FALL, op: 2'b00};
        end else if (cfg_we) begin
            mode.src  <= cfg_wdata[7:6];
            mode.pair <= pair_e'(cfg_wdata[3:2]);
            mode.op   <= cfg_wdata[1:0];
        end
    end

    assign cfg_rdata = {mode.src, ovf, 1'b0, mode.pair, mode.op};

    pm_edge_det #(.STAGES(SYNC_STAGES)) i_edge (
        .clk(clk), .rst(rst), .pin(pin_in), .rise(rise), .fall(fall)
    );

    pm_tick_mux #(.N_SRC(4)) i_tick (
        .strobes({tick_aux32, tick_div32, tick_div8, tick_base}),
        .sel(mode.src), .tick(tick_sel)
    );

    assign meas_on = run && (mode.op == OP_MEAS);
    assign hit     = meas_on && edge_hit(mode.pair, rise, fall);

    pm_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst(rst), .en(meas_on), .tick(tick_sel),
        .restart(hit), .cnt(cnt), .wrap(wrap)
    );

    // First qualifying edge after enable only arms the capture path.
    always_ff @(posedge clk) begin
        if (rst || !meas_on) primed <= 1'b0;
        else if (hit)        primed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_value <= '0;
            cap_event <= 1'b0;
        end else begin
            cap_event <= hit && primed;
            if (hit && primed) cap_value <= cnt;
        end
    end

    // Overflow: set by wrap; a write clears it only after a later tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf       <= 1'b0;
            ovf_armed <= 1'b0;
        end else if (wrap) begin
            ovf       <= 1'b1;
            ovf_armed <= 1'b0;
        end else begin
            if (tick_sel && ovf) ovf_armed <= 1'b1;
            if (cfg_we && run && ovf && ovf_armed) ovf <= 1'b0;
        end
    end

    p_cap_needs_run_r8: assert property (@(posedge clk) disable iff (rst)
        cap_event |-> ($past(run) && $past(mode.op) == OP_MEAS));

    p_reserved_pair_r9: assert property (@(posedge clk) disable iff (rst)
        cap_event |-> ($past(mode.pair) != PAIR_NONE));

    p_restart_zero_r3: assert property (@(posedge clk) disable iff (rst)
        cap_event |-> (cnt == '0));

    p_cap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !cap_event |-> $stable(cap_value));

    p_ovf_set_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(tick_sel));

    p_ovf_clear_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf) |-> ($past(cfg_we) && $past(run)));
endmodule

// File: tb/test_pulse_meter.sv
module test_pulse_meter;
    logic        clk = 1'b0;
    logic        rst, cfg_we, run, pin_in, base_on;
    logic [7:0]  cfg_wdata, cfg_rdata;
    logic [15:0] cap_value;
    logic        cap_event;
    logic [31:0] cyc = 0;
    int checks = 0, fails = 0, ev_cnt = 0;
    logic [15:0] last_cap = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) if (!rst && cap_event) begin ev_cnt++; last_cap = cap_value; end

    pulse_meter i_pulse_meter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .run(run), .tick_base(base_on), .tick_div8(cyc[2:0] == 3'd0),
        .tick_div32(cyc[4:0] == 5'd0), .tick_aux32(cyc[5:0] == 6'd0),
        .pin_in(pin_in), .cap_value(cap_value), .cap_event(cap_event)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
    endtask

    task automatic do_reset();
        rst = 1; run = 0; cfg_we = 0; cfg_wdata = 0; pin_in = 0; base_on = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic write_mode(input logic [7:0] v);
        cfg_we = 1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic hold(input logic v, input int n);
        pin_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(cfg_rdata == 8'h00, "R1 rdata", cfg_rdata, 0);
        chk(cap_value == 0, "R1 cap_value", cap_value, 0);
        chk(cap_event == 0, "R1 cap_event", cap_event, 0);
        write_mode(8'hFF);
        chk(cfg_rdata == 8'hCF, "R2 readback", cfg_rdata, 8'hCF);
    endtask

    task automatic t_rise();
        int e0;
        do_reset(); write_mode(8'h06); run = 1; e0 = ev_cnt;
        hold(1, 10);
        chk(ev_cnt == e0, "R7 first edge", ev_cnt - e0, 0);
        hold(0, 20);
        chk(ev_cnt == e0, "R3 fall ignored", ev_cnt - e0, 0);
        pin_in = 1;
        repeat (2) @(negedge clk);
        chk(cap_event == 0, "R6 early", cap_event, 0);
        @(negedge clk);
        chk(cap_event == 1, "R6 on time", cap_event, 1);
        chk(cap_value == 29, "R3 period", cap_value, 29);
        @(negedge clk);
        chk(cap_event == 0, "R6 one cycle", cap_event, 0);
        repeat (6) @(negedge clk);
        hold(0, 40); hold(1, 6);
        chk(ev_cnt - e0 == 2, "R3 count", ev_cnt - e0, 2);
        chk(last_cap == 49, "R3 period2", last_cap, 49);
    endtask

    task automatic t_fall();
        int e0;
        do_reset(); write_mode(8'h02); run = 1; e0 = ev_cnt;
        hold(1, 10); hold(0, 10); hold(1, 15); hold(0, 10);
        chk(ev_cnt - e0 == 1, "R4 count", ev_cnt - e0, 1);
        chk(last_cap == 24, "R4 period", last_cap, 24);
    endtask

    task automatic t_width();
        int e0;
        do_reset(); write_mode(8'h0A); run = 1; e0 = ev_cnt;
        hold(1, 12); hold(0, 25);
        chk(last_cap == 11, "R5 high", last_cap, 11);
        hold(1, 30);
        chk(last_cap == 24, "R5 low", last_cap, 24);
        hold(0, 8);
        chk(last_cap == 29, "R5 high2", last_cap, 29);
        chk(ev_cnt - e0 == 3, "R5 count", ev_cnt - e0, 3);
    endtask

    task automatic t_src(input logic [7:0] m, input int half, input string req);
        int e0;
        do_reset(); write_mode(m); run = 1; e0 = ev_cnt;
        hold(1, half); hold(0, half); hold(1, half); hold(0, 10);
        chk(ev_cnt - e0 == 1, req, ev_cnt - e0, 1);
        chk(last_cap == 9 || last_cap == 10, req, last_cap, 10);
    endtask

    task automatic t_disabled();
        int e0;
        do_reset(); write_mode(8'h06); run = 0; e0 = ev_cnt;
        hold(1, 10); hold(0, 10); hold(1, 10); hold(0, 10);
        chk(ev_cnt == e0, "R8 run low", ev_cnt - e0, 0);
        write_mode(8'h05); run = 1;
        hold(1, 10); hold(0, 10); hold(1, 10); hold(0, 10);
        chk(ev_cnt == e0, "R8 op not meas", ev_cnt - e0, 0);
        write_mode(8'h0E);
        hold(1, 10); hold(0, 10); hold(1, 10); hold(0, 10);
        chk(ev_cnt == e0, "R9 reserved pairing", ev_cnt - e0, 0);
    endtask

    task automatic t_ovf();
        int k = 0;
        do_reset(); write_mode(8'h06); run = 1;
        while (!cfg_rdata[5] && k < 70000) begin @(negedge clk); k++; end
        base_on = 0;
        chk(k == 65536, "R11 wrap time", k, 65536);
        chk(cfg_rdata == 8'h26, "R11 flag", cfg_rdata, 8'h26);
        write_mode(8'h06);
        chk(cfg_rdata[5] == 1, "R12 no tick yet", cfg_rdata[5], 1);
        base_on = 1; @(negedge clk); base_on = 0;
        run = 0; write_mode(8'h06);
        chk(cfg_rdata[5] == 1, "R12 run low", cfg_rdata[5], 1);
        run = 1; write_mode(8'h06);
        chk(cfg_rdata[5] == 0, "R12 cleared", cfg_rdata[5], 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_width();
        t_src(8'h46, 40, "R10 div8");
        t_src(8'h86, 160, "R10 div32");
        t_src(8'hC6, 320, "R10 aux32");
        t_disabled();
        t_ovf();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule